// File: doc/BRIEF.md
# Nibble-wide bidirectional I/O port with direction control

This block is a 4-pin general-purpose I/O port whose pins sit in the upper half (bits 7..4) of an 8-bit register word. It has two registers on a simple synchronous bus: a pin-data register and a direction register. Each register is decoded at two addresses that differ only in address bit 8. Reads of the data register return the pin levels, taken through a two-stage synchronizer and not from the output latches. Writes load the output latches. Each pin is modelled as three signals: an output value, an output enable and an input sample. An external per-pin analog-select input forces that pin's read value to zero.

Besides full writes, the bus has single-bit set and clear commands. On the data register such a command rebuilds the whole latch nibble from the current pin readings, with only the addressed bit changed. This means any pin that is held by an outside driver has its level copied into its own latch. The pin at bit 6 drives in open-drain fashion: it can only pull low. The bus has four commands: 0 idle, 1 write, 2 set bit, 3 clear bit. Read data depends only on the address and is valid in the same cycle. Every command takes effect at the next rising clock edge.

Top module: `gpio_nibble_port`

## Requirements
- R1: Register bits 3..0 of both registers always read 0, and writing them has no effect on any pin or on any later read.
- R2: For a push-pull pin (bits 7, 5, 4), a direction bit of 0 asserts pad_oe and puts the latch value on pad_out. A direction bit of 1 deasserts pad_oe.
- R3: After reset, all four direction bits are 1, all pad_oe are 0, and the direction register reads 0xF0.
- R4: A data-register read returns the pad_in levels in bits 7..4, two clock edges after they change. A write command (1) to the data register loads wdata[7:4] into the output latches.
- R5: A set (2) or clear (3) command on the data register with bus_bit in 4..7 loads the latches with the current data-register read value, with that one bit forced to 1 or 0. With bus_bit in 0..3 it loads the read value unchanged.
- R6: The bit-6 pin never drives high. Its pad_out is 0, and pad_oe is 1 only when its direction bit is 0 and its latch is 0.
- R7: A pin whose ana_sel bit is 1 reads as 0 in the data register, whatever its level. Its direction bit still controls pad_oe.
- R8: The data register responds at 0x006 and 0x106, and the direction register at 0x086 and 0x186. Any other address reads 0, and commands to it change nothing.
- R9: A set or clear command on the direction register changes only the addressed direction bit.
- R10: An idle command (0) changes no register state, whatever the address and write data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 9 | Register address |
| bus_cmd | input | 2 | 0 idle, 1 write, 2 set bit, 3 clear bit |
| bus_bit | input | 3 | Bit index for set/clear |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | 4 | Sampled pin levels, bit 0 = register bit 4 |
| ana_sel | input | 4 | Per-pin analog select, 1 masks the read |
| pad_out | output | 4 | Output drive values |
| pad_oe | output | 4 | Output drive enables |

## Verification
The bench builds the block with its default parameters: a 4-pin nibble at bits 7..4, the open-drain pin at bit 6, a two-stage synchronizer and a mirror on address bit 8. With these values every direction code, every latch code, every pin pattern combined with every analog mask, and every start state under each bit operation can be swept in full. A pin model in the bench resolves the drive, the open-drain pull-up and forced external levels. This makes it possible to check that a set or clear picks up a level the pin was forced to from outside, and that reads lag the pins by exactly two edges.

// File: rtl/gpio_nibble_port.sv
module gpio_nibble_port #(
  parameter int ADDR_W      = 9,
  parameter int DATA_W      = 8,
  parameter int LO          = 4,
  parameter int NPIN        = 4,
  parameter int OD_BIT      = 6,
  parameter int SYNC_STAGES = 2,
  parameter int MIRROR_BIT  = 8,
  parameter logic [8:0] DATA_BASE = 9'h006,
  parameter logic [8:0] DIR_BASE  = 9'h086
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [1:0]                bus_cmd,
  input  logic [$clog2(DATA_W)-1:0] bus_bit,
  input  logic [DATA_W-1:0]         bus_wdata,
  output logic [DATA_W-1:0]         bus_rdata,
  input  logic [NPIN-1:0]           pad_in,
  input  logic [NPIN-1:0]           ana_sel,
  output logic [NPIN-1:0]           pad_out,
  output logic [NPIN-1:0]           pad_oe
);
  localparam int HI = LO + NPIN - 1;
  localparam int OD_IDX = OD_BIT - LO;
  localparam logic [1:0] CMD_WR = 2'd1, CMD_SET = 2'd2, CMD_CLR = 2'd3;
  localparam logic [ADDR_W-1:0] AMASK = ~(ADDR_W'(1) << MIRROR_BIT);

  logic [NPIN-1:0] sync_q [SYNC_STAGES];
  logic [NPIN-1:0] dir_q, dir_d, lat_q, lat_d, pin_view;
  logic            hit_data, hit_dir, is_bitop, in_rng;

  assign hit_data = (bus_addr & AMASK) == ADDR_W'(DATA_BASE);
  assign hit_dir  = (bus_addr & AMASK) == ADDR_W'(DIR_BASE);
  assign is_bitop = (bus_cmd == CMD_SET) || (bus_cmd == CMD_CLR);
  assign in_rng   = (int'(bus_bit) >= LO) && (int'(bus_bit) <= HI);

  always_ff @(posedge clk) begin
    if (!rst_n) sync_q[0] <= '0;
    else        sync_q[0] <= pad_in;
  end

  for (genvar k = 1; k < SYNC_STAGES; k++) begin : g_sync
    always_ff @(posedge clk) begin
      if (!rst_n) sync_q[k] <= '0;
      else        sync_q[k] <= sync_q[k-1];
    end
  end

  assign pin_view = sync_q[SYNC_STAGES-1] & ~ana_sel;

  function automatic logic [DATA_W-1:0] place(input logic [NPIN-1:0] nib);
    logic [DATA_W-1:0] r;
    r = '0;
    r[HI:LO] = nib;
    return r;
  endfunction

  function automatic logic [NPIN-1:0] edit(input logic [NPIN-1:0] src,
                                           input logic [$clog2(DATA_W)-1:0] b,
                                           input logic v);
    logic [NPIN-1:0] e;
    e = src;
    for (int i = 0; i < NPIN; i++)
      if (int'(b) == LO + i) e[i] = v;
    return e;
  endfunction

  assign bus_rdata = hit_data ? place(pin_view) :
                     hit_dir  ? place(dir_q)    : '0;

  always_comb begin
    lat_d = lat_q;
    dir_d = dir_q;
    if (bus_cmd == CMD_WR) begin
      if (hit_data) lat_d = bus_wdata[HI:LO];
      if (hit_dir)  dir_d = bus_wdata[HI:LO];
    end else if (is_bitop) begin
      if (hit_data) lat_d = edit(pin_view, bus_bit, bus_cmd == CMD_SET);
      if (hit_dir)  dir_d = edit(dir_q, bus_bit, bus_cmd == CMD_SET);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) dir_q <= '1;
    else        dir_q <= dir_d;
  end

  always_ff @(posedge clk) lat_q <= lat_d;

  for (genvar i = 0; i < NPIN; i++) begin : g_pad
    if (LO + i == OD_BIT) begin : g_od
      assign pad_out[i] = 1'b0;
      assign pad_oe[i]  = ~dir_q[i] & ~lat_q[i];
    end else begin : g_pp
      assign pad_out[i] = lat_q[i];
      assign pad_oe[i]  = ~dir_q[i];
    end
  end

  AST_RESET_ALL_INPUTS: assert property (@(posedge clk)
    !rst_n |=> (pad_oe == '0)); // R3

  AST_WRITE_LOADS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_WR && hit_data) |=> (lat_q == $past(bus_wdata[HI:LO]))); // R4

  AST_BITOP_ONE_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (is_bitop && hit_data) |=> ($countones(lat_q ^ $past(pin_view)) <= 1)); // R5

  AST_OD_RELEASES_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == CMD_WR && hit_data && bus_wdata[OD_BIT]) |=> !pad_oe[OD_IDX]); // R6

  AST_IDLE_KEEPS_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_cmd == 2'd0) |=> $stable(dir_q)); // R10
endmodule

// File: tb/gpio_nibble_port_bench.sv
module gpio_nibble_port_bench;
  logic clk = 0, rst_n = 0;
  logic [8:0] bus_addr = '0;
  logic [1:0] bus_cmd = '0;
  logic [2:0] bus_bit = '0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic [3:0] pad_in, ana_sel = '0, pad_out, pad_oe;
  logic [3:0] pull = 4'hF, force_en = '0, force_val = '0;
  logic [3:0] m_dir = 4'hF, m_lat = '0;
  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_nibble_port u_gpio_nibble_port (
    .clk, .rst_n, .bus_addr, .bus_cmd, .bus_bit, .bus_wdata, .bus_rdata,
    .pad_in, .ana_sel, .pad_out, .pad_oe);

  function automatic logic [3:0] pins_exp(input logic [3:0] d, input logic [3:0] l,
                                          input logic [3:0] fe, input logic [3:0] fv,
                                          input logic [3:0] pu);
    logic [3:0] p;
    for (int i = 0; i < 4; i++) begin
      if (fe[i]) p[i] = fv[i];
      else if (!d[i] && !(i == 2 && l[i])) p[i] = l[i];
      else p[i] = pu[i];
    end
    return p;
  endfunction

  always_comb
    for (int i = 0; i < 4; i++)
      pad_in[i] = force_en[i] ? force_val[i] : (pad_oe[i] ? pad_out[i] : pull[i]);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic cmd(input logic [8:0] a, input logic [1:0] c, input logic [2:0] b,
                     input logic [7:0] w);
    logic [3:0] pv;
    @(negedge clk);
    pv = pins_exp(m_dir, m_lat, force_en, force_val, pull) & ~ana_sel;
    bus_addr = a; bus_cmd = c; bus_bit = b; bus_wdata = w;
    if (a[7:0] == 8'h06) begin
      if (c == 1) m_lat = w[7:4];
      else if (c >= 2) begin
        m_lat = pv;
        if (b >= 4) m_lat[b-4] = (c == 2);
      end
    end else if (a[7:0] == 8'h86) begin
      if (c == 1) m_dir = w[7:4];
      else if (c >= 2 && b >= 4) m_dir[b-4] = (c == 2);
    end
    @(negedge clk);
    bus_cmd = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic rd(input logic [8:0] a, output logic [7:0] d);
    bus_addr = a; bus_cmd = 0;
    #2 d = bus_rdata;
  endtask

  task automatic chk_pads(input string req);
    logic [3:0] eo, ee;
    eo = m_lat & 4'b1011;
    ee = ~m_dir & ~(4'b0100 & m_lat);
    chk(req, {pad_out, pad_oe}, {eo, ee});
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    chk("R3 oe", {4'h0, pad_oe}, 8'h00);
    rd(9'h086, d); chk("R3 dir", d, 8'hF0);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R2 R8 R1: direction sweep at both mirrors, latch all zero
    cmd(9'h006, 1, 0, 8'h00);
    for (int v = 0; v < 16; v++) begin
      cmd(v[0] ? 9'h186 : 9'h086, 1, 0, {v[3:0], 4'hF});
      rd(9'h086, d); chk("R8 R1 dir", d, {v[3:0], 4'h0});
      rd(9'h186, d); chk("R8 dir mirror", d, {v[3:0], 4'h0});
      chk_pads("R2 oe");
    end

    // R4 R6: data write sweep, all outputs
    cmd(9'h086, 1, 0, 8'h00);
    for (int v = 0; v < 16; v++) begin
      cmd(v[0] ? 9'h106 : 9'h006, 1, 0, {v[3:0], 4'hF});
      chk_pads("R4 R6 latch");
      rd(9'h006, d);
      chk("R4 R1 read", d, {pins_exp(m_dir, m_lat, force_en, force_val, pull), 4'h0});
    end

    // R7: input sweep with analog masks
    cmd(9'h086, 1, 0, 8'hF0);
    for (int p = 0; p < 16; p++)
      for (int a = 0; a < 16; a++) begin
        @(negedge clk);
        pull = p[3:0]; ana_sel = a[3:0];
        repeat (2) @(negedge clk);
        rd(9'h106, d); chk("R7 read", d, {p[3:0] & ~a[3:0], 4'h0});
      end
    ana_sel = 4'hF;
    cmd(9'h086, 1, 0, 8'h00);
    chk_pads("R7 dir applies");
    ana_sel = 4'h0;
    cmd(9'h086, 1, 0, 8'hF0);

    // R4: two-edge lag
    @(negedge clk); pull = 4'h0;
    repeat (2) @(negedge clk);
    pull = 4'hA;
    @(negedge clk); rd(9'h006, d); chk("R4 lag1", d, 8'h00);
    @(negedge clk); rd(9'h006, d); chk("R4 lag2", d, 8'hA0);
    pull = 4'hF;

    // R5: set/clear sweep over start states
    cmd(9'h086, 1, 0, 8'h00);
    for (int s = 0; s < 16; s++)
      for (int b = 4; b < 8; b++)
        for (int c = 2; c < 4; c++) begin
          cmd(9'h006, 1, 0, {s[3:0], 4'h0});
          cmd(9'h006, c[1:0], b[2:0], 8'h00);
          chk_pads("R5 bitop");
        end

    // R5: set bit 4 while pin 5 forced high from outside
    cmd(9'h006, 1, 0, 8'h00);
    @(negedge clk); force_en = 4'b0010; force_val = 4'b0010;
    repeat (2) @(negedge clk);
    cmd(9'h006, 2, 4, 8'h00);
    chk("R5 contention", {pad_out, pad_oe}, {4'b0011, 4'hF});
    // R5: bit index below 4 rebuilds from pins only
    @(negedge clk); force_val = 4'b0000;
    repeat (2) @(negedge clk);
    cmd(9'h106, 3, 2, 8'h00);
    chk("R5 low index", {pad_out, pad_oe}, {4'b0001, 4'hF});
    force_en = 4'h0;

    // R9: direction bit operations
    for (int b = 4; b < 8; b++) begin
      cmd(9'h086, 1, 0, 8'h50);
      cmd(9'h186, 2, b[2:0], 8'h00);
      rd(9'h086, d); chk("R9 set", d, {m_dir, 4'h0});
      cmd(9'h086, 3, b[2:0], 8'h00);
      rd(9'h086, d); chk("R9 clr", d, {m_dir, 4'h0});
    end

    // R8: unmapped address
    cmd(9'h086, 1, 0, 8'h00);
    cmd(9'h006, 1, 0, 8'h90);
    cmd(9'h007, 1, 0, 8'hF0);
    cmd(9'h087, 1, 0, 8'hF0);
    rd(9'h007, d); chk("R8 unmapped read", d, 8'h00);
    chk_pads("R8 unmapped write");

    // R10: idle with data
    cmd(9'h006, 0, 0, 8'h60);
    cmd(9'h086, 0, 0, 8'hF0);
    chk_pads("R10 idle");

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule